// File: doc/BRIEF.md
# Period-Match Timer with Deferred Wrap

This block is a 16-bit up-counting timer for a large SoC. A register write port configures the timer and can load the counter. The counter advances once per prescaled tick. The tick source is either an internal rate of one pulse every second system clock, or an external pin. The pin is brought into the system clock domain through two flops and an edge detector.

A comparator checks the counter against a period register on every system clock cycle and drives a match output. When the two are equal, the counter does not clear at once. It returns to zero on the following tick. The match therefore lasts for a whole tick interval, and during that interval it keeps setting a sticky interrupt flag. Software ends the condition by loading the counter with zero and then clearing the flag.

Register map on the write port:
- Address 0 is control: bit 0 enables the timer, bit 1 selects the external pin, and bits [3:2] hold the prescale code.
- Address 1 loads the counter.
- Address 2 holds the period.
- Address 3 clears the flag.

Top module: `period_timer`

## Requirements
- R1: After reset the counter reads 0, the flag is 0, the match is 0, the period register is all ones and the timer is disabled.
- R2: With control bit 0 set, the counter rises by exactly one per prescaled tick. With bit 0 clear, the counter holds its value.
- R3: With control bit 1 clear, the source produces one pulse every second system clock. Counting starts two cycles after a control or counter write, so with code 0 the counter gains 5 in the 10 cycles after such a write.
- R4: With control bit 1 set, each rising edge on the external pin gives exactly one count. The edge is taken after a two-flop synchronizer and yields a single-cycle pulse.
- R5: The prescale code in control bits [3:2] divides the source by 1, 8, 64 or 256 for codes 0, 1, 2 and 3. The prescaler restarts on any control or counter write.
- R6: The match output is high in every system cycle in which the counter equals the period, whether or not a tick occurs.
- R7: A tick that arrives while the counter equals the period loads 0 instead of incrementing. Before that tick the counter holds the period value, so a period P gives P+1 counts per cycle (60 counts for P = 59).
- R8: The flag is set on the cycle after any cycle with match high. It then stays set until a write to address 3.
- R9: A flag clear written during a cycle in which the match is high leaves the flag set.
- R10: A counter write takes priority over ticking. Writing 0 removes the match from the next cycle, so a later flag clear holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_cnt_i | input | 1 | External count pin, asynchronous |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register select: 0 control, 1 counter, 2 period, 3 flag clear |
| wr_data_i | input | 16 | Write data |
| count_o | output | 16 | Current counter value |
| match_o | output | 1 | High while counter equals period |
| flag_o | output | 1 | Sticky match interrupt flag |

## Verification
A flag-clear write and a live match can land in the same system cycle. This happens because the counter sits at the period value for a whole prescaled tick interval. The bench provokes the overlap with a slow prescale and a period of 3: it issues the clear write while the counter reads 3, and expects the flag to still read 1 afterwards. It then loads the counter with 0, repeats the clear, and expects the flag to fall and to stay low. This shows that the fix only works once the match has been removed.

// File: rtl/period_timer.sv
module period_timer #(
  parameter int WIDTH = 16,
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_cnt_i,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  logic [WIDTH-1:0] wr_data_i,
  output logic [WIDTH-1:0] count_o,
  output logic             match_o,
  output logic             flag_o
);
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_CNT  = 2'd1;
  localparam logic [1:0] A_PER  = 2'd2;
  localparam logic [1:0] A_CLR  = 2'd3;

  logic             run_q, ext_sel_q;
  logic [1:0]       psel_q;
  logic [WIDTH-1:0] cnt_q, per_q;
  logic             flag_q, half_q;
  logic [2:0]       sync_q;
  logic [PRE_W-1:0] pre_q, pre_lim;

  wire ctrl_wr = wr_en_i && (wr_addr_i == A_CTRL);
  wire cnt_wr  = wr_en_i && (wr_addr_i == A_CNT);
  wire per_wr  = wr_en_i && (wr_addr_i == A_PER);
  wire clr_wr  = wr_en_i && (wr_addr_i == A_CLR);
  wire restart = ctrl_wr || cnt_wr;

  wire ext_rise = sync_q[1] & ~sync_q[2];
  wire src_tick = ext_sel_q ? ext_rise : half_q;
  wire tick     = run_q && src_tick && (pre_q == pre_lim);
  wire match    = (cnt_q == per_q);

  always_comb begin
    case (psel_q)
      2'd0:    pre_lim = PRE_W'(0);
      2'd1:    pre_lim = PRE_W'(7);
      2'd2:    pre_lim = PRE_W'(63);
      default: pre_lim = PRE_W'(255);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q     <= 1'b0;
      ext_sel_q <= 1'b0;
      psel_q    <= 2'd0;
      per_q     <= '1;
    end else begin
      if (ctrl_wr) begin
        run_q     <= wr_data_i[0];
        ext_sel_q <= wr_data_i[1];
        psel_q    <= wr_data_i[3:2];
      end
      if (per_wr) per_q <= wr_data_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      half_q <= 1'b0;
      pre_q  <= '0;
    end else begin
      sync_q <= {sync_q[1:0], ext_cnt_i};
      if (restart) begin
        half_q <= 1'b0;
        pre_q  <= '0;
      end else if (run_q) begin
        half_q <= ~half_q;
        if (src_tick) pre_q <= (pre_q == pre_lim) ? '0 : pre_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (cnt_wr)    cnt_q <= wr_data_i;
      else if (tick) cnt_q <= match ? '0 : cnt_q + 1'b1;
      if (match)       flag_q <= 1'b1;
      else if (clr_wr) flag_q <= 1'b0;
    end
  end

  assign count_o = cnt_q;
  assign match_o = match;
  assign flag_o  = flag_q;
endmodule

// File: rtl/period_timer_chk.sv
module period_timer_chk #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             tick,
  input logic             ext_rise,
  input logic             wr_en,
  input logic [1:0]       wr_addr,
  input logic [WIDTH-1:0] wr_data,
  input logic [WIDTH-1:0] cnt,
  input logic [WIDTH-1:0] per,
  input logic             match,
  input logic             flag
);
  wire cnt_wr = wr_en && (wr_addr == 2'd1);
  wire clr_wr = wr_en && (wr_addr == 2'd3);
  wire per_wr = wr_en && (wr_addr == 2'd2);

  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cnt_wr) |=> $stable(cnt)); // R2
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (cnt != per) && !cnt_wr) |=> (cnt == $past(cnt) + 1'b1)); // R2
  AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ext_rise |=> !ext_rise); // R4
  AST_MATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (match && !tick && !cnt_wr && !per_wr) |=> match); // R6
  AST_DEFERRED_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && match && !cnt_wr) |=> (cnt == '0)); // R7
  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> flag); // R8
  AST_CLEAR_LOST: assert property (@(posedge clk) disable iff (!rst_n)
    (match && clr_wr) |=> flag); // R9
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> (cnt == $past(wr_data))); // R10
endmodule

bind period_timer period_timer_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run_q), .tick(tick), .ext_rise(ext_rise),
  .wr_en(wr_en_i), .wr_addr(wr_addr_i), .wr_data(wr_data_i),
  .cnt(cnt_q), .per(per_q), .match(match), .flag(flag_q)
);

// File: tb/sim_period_timer.sv
module sim_period_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ext = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'd0;
  logic [15:0] wr_data = 16'd0;
  logic [15:0] count;
  logic        match, flag;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  localparam int NV = 7;
  localparam int VPER [NV] = '{5, 5, 5, 5, 59, 59, 0};
  localparam int VPUL [NV] = '{3, 5, 6, 13, 59, 60, 4};

  always #5 clk = ~clk;

  period_timer u0 (
    .clk(clk), .rst_n(rst_n), .ext_cnt_i(ext), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .count_o(count), .match_o(match), .flag_o(flag)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse();
    @(negedge clk); ext = 1'b1;
    repeat (3) @(negedge clk);
    ext = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic wait_edges(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic setup_period3();
    wr(2'd0, 16'h0); wr(2'd2, 16'd3); wr(2'd1, 16'd0); wr(2'd3, 16'd0);
    wr(2'd0, 16'h5);
    wait_edges(50);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 count", count, 0);
    chk("R1 flag", flag, 0);
    chk("R1 match", match, 0);
    wait_edges(5);
    chk("R1 disabled", count, 0);

    for (int i = 0; i < NV; i++) begin
      wr(2'd0, 16'h0); wr(2'd2, 16'(VPER[i])); wr(2'd1, 16'd0); wr(2'd3, 16'd0);
      wr(2'd0, 16'h3);
      for (int k = 0; k < VPUL[i]; k++) pulse();
      chk("R4/R7 count", count, VPUL[i] % (VPER[i] + 1));
      chk("R6 match", match, int'((VPUL[i] % (VPER[i] + 1)) == VPER[i]));
      chk("R8 flag", flag, int'(VPUL[i] >= VPER[i]));
    end

    wr(2'd0, 16'h0); wr(2'd2, 16'hFFFF); wr(2'd1, 16'd0); wr(2'd3, 16'd0);
    wr(2'd0, 16'h1);
    wait_edges(10);
    chk("R3 half rate", count, 5);
    wr(2'd0, 16'h5);
    wait_edges(48);
    chk("R5 div8", count, 8);
    wr(2'd0, 16'hD);
    wait_edges(511);
    chk("R5 div256 early", count, 8);
    wait_edges(1);
    chk("R5 div256", count, 9);
    wr(2'd0, 16'h0);
    wait_edges(40);
    chk("R2 hold off", count, 9);
    wr(2'd1, 16'h1234);
    chk("R10 load", count, 16'h1234);

    setup_period3();
    chk("R7 holds at period", count, 3);
    chk("R6 match window", match, 1);
    chk("R8 flag set", flag, 1);
    wr(2'd3, 16'd0);
    chk("R9 clear lost", flag, 1);
    wait_edges(13);
    chk("R7 deferred wrap", count, 0);
    chk("R6 match ends", match, 0);
    chk("R8 sticky", flag, 1);
    wr(2'd3, 16'd0);
    chk("R8 cleared", flag, 0);

    setup_period3();
    chk("R7 at period again", count, 3);
    wr(2'd1, 16'd0);
    chk("R10 match gone", match, 0);
    wr(2'd3, 16'd0);
    chk("R10 clear holds", flag, 0);
    wait_edges(4);
    chk("R10 flag stays low", flag, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule